// File: doc/BRIEF.md
# Interleaved Multi-Bank Block Fill Controller

The controller serves cache block fills. A fill request gives a starting word address and a word count. The controller spreads the words over a set of independent banks, which default to four, so that their slow fixed access times overlap. A bank is picked by the low bits of the word address, and the remaining bits select the row inside that bank. All banks whose words are needed are started together after one shared address phase. The words then come back over a one-word response bus, one at a time and in increasing address order.

Each bank is a model with a fixed access time. A bank cannot start a new access while an earlier access is still counting down. It also cannot start one while it holds a word that has not yet been moved onto the response bus. Fills longer than the bank count therefore stall on the bank reuse, which shows at the ports as a wider gap between words. A fill cannot be interrupted. The request port refuses new work until the done pulse, and a new request can be taken in the done cycle itself.

Top module: `ilv_fill_ctrl`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and rsp_done are both 0.
- R2: Word address a is held in bank a mod 4, at row a div 4. Its read value is the low 32 bits of a × 0x9E3779B1. The words of a fill come back in the order a, a+1, a+2, and so on.
- R3: A request whose req_len field holds L returns exactly L+1 words. Each word is marked by one cycle of rsp_valid.
- R4: A request is accepted in a cycle where req_valid and req_ready are both 1. This cycle is counted as cycle 0. From cycle 1 until the done cycle, req_ready stays 0, and req_valid, req_addr and req_len have no effect on the fill in progress.
- R5: The first word appears in cycle 31. This is made of the 4-cycle address phase (cycles 0 to 3), 24 access cycles, and a 4-cycle transfer that ends with rsp_valid.
- R6: A two-word fill shows its last rsp_valid in cycle 35, so the whole fill spans 36 cycles. Without overlap, two words would need 64 cycles.
- R7: Each word takes 4 transfer cycles, and it cannot start before the previous word's valid cycle has ended. Words whose banks are already holding data therefore appear every 4 cycles. A four-word fill shows valid in cycles 31, 35, 39 and 43.
- R8: A word that reuses a bank waits for that bank's previous word. The bank starts the new access at the end of the previous word's first transfer cycle, and the new data is ready 25 cycles after that first transfer cycle. An eight-word fill delivers its last word in cycle 68, and a sixteen-word fill in cycle 118.
- R9: rsp_done is high for exactly one cycle, the cycle right after the last rsp_valid. req_ready is 1 in that same cycle, so a new request can be accepted there.
- R10: Word addresses wrap modulo 4096. A fill starting at 0xFFE returns the words at 0xFFE, 0xFFF, 0x000 and 0x001, with the same timing as any other four-word fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fill request present |
| req_ready | output | 1 | Controller is idle and can take a request |
| req_addr | input | 12 | Starting word address |
| req_len | input | 4 | Number of words minus one |
| rsp_valid | output | 1 | rsp_data holds the next word of the fill |
| rsp_data | output | 32 | Returned word |
| rsp_done | output | 1 | One-cycle pulse after the last word |

## Verification
Suppose a bank index or a row is decoded wrongly. The first word's value at the response bus shows it, in cycle 31 of the fill. Suppose instead a busy counter or a ready flag in a bank is corrupted. Then a word appears early, or late, or a later word repeats stale data, and this appears first at the fifth word of a long fill, where a bank is reused. Suppose finally that the word counter or the transfer counter is wrong. Then the spacing between valid strobes, the number of words or the done cycle moves, and the fill's end shows this one cycle after the last word.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_ADDR = 2'd1,
    FILL_RUN  = 2'd2
  } fill_state_e;

  // Multiplier that gives every word address a distinct read value
  localparam logic [63:0] WORD_MIX = 64'h0000_0000_9E37_79B1;

  function automatic logic [63:0] word_value(input logic [31:0] waddr);
    return {32'd0, waddr} * WORD_MIX;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
// One memory bank model with a fixed access time and a one-word output slot.
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int BANK_IDX  = 0,
  parameter int ACC_CYC   = 24,
  parameter int ROW_W     = ADDR_W - $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ROW_W-1:0]  row,
  input  logic              take,
  output logic              busy,
  output logic              rdy,
  output logic [DATA_W-1:0] data
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int CNT_W  = $clog2(ACC_CYC + 1);
  localparam logic [BANK_W-1:0] IDX = BANK_W'(BANK_IDX);

  logic [CNT_W-1:0]  cnt_q;
  logic [ROW_W-1:0]  row_q;
  logic              rdy_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] gaddr;

  assign gaddr = {row_q, IDX};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      row_q  <= '0;
      rdy_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (start) begin
        cnt_q <= CNT_W'(ACC_CYC);
        row_q <= row;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (cnt_q == CNT_W'(1)) begin
        rdy_q  <= 1'b1;
        data_q <= DATA_W'(word_value(32'(gaddr)));
      end else if (take) begin
        rdy_q <= 1'b0;
      end
    end
  end

  assign busy = (cnt_q != '0);
  assign rdy  = rdy_q;
  assign data = data_q;

endmodule

// File: rtl/ilv_issue.sv
// Per-bank issue logic: each bank walks its own words of the fill in order.
module ilv_issue #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int LEN_W     = 4,
  parameter int ROW_W     = ADDR_W - $clog2(NUM_BANKS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load,
  input  logic                            en,
  input  logic [ADDR_W-1:0]               base,
  input  logic [LEN_W-1:0]                last_idx,
  input  logic [NUM_BANKS-1:0]            bank_busy,
  input  logic [NUM_BANKS-1:0]            bank_rdy,
  input  logic [NUM_BANKS-1:0]            bank_take,
  output logic [NUM_BANKS-1:0]            start,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] row
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int IDX_W  = LEN_W + 2;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
    logic [IDX_W-1:0]  rnd_q;
    logic [BANK_W-1:0] lane;
    logic [IDX_W-1:0]  widx;
    logic [ADDR_W-1:0] gaddr;
    logic              pending;
    logic              free;

    assign lane    = BANK_W'(b) - base[BANK_W-1:0];
    assign widx    = (rnd_q << BANK_W) | IDX_W'(lane);
    assign gaddr   = base + ADDR_W'(widx);
    assign pending = (widx <= IDX_W'(last_idx));
    assign free    = !bank_busy[b] && (!bank_rdy[b] || bank_take[b]);
    assign start[b] = en && pending && free;
    assign row[b]   = gaddr[ADDR_W-1:BANK_W];

    always_ff @(posedge clk) begin
      if (rst || load) begin
        rnd_q <= '0;
      end else if (start[b]) begin
        rnd_q <= rnd_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ilv_return.sv
// In-order return engine: moves words from the banks to the response bus.
module ilv_return #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 4,
  parameter int XFER_CYC  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             load,
  input  logic                             active,
  input  logic [$clog2(NUM_BANKS)-1:0]     first_bank,
  input  logic [LEN_W-1:0]                 last_idx,
  input  logic [NUM_BANKS-1:0]             bank_rdy,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data,
  output logic [NUM_BANKS-1:0]             take,
  output logic                             rsp_valid,
  output logic [DATA_W-1:0]                rsp_data,
  output logic                             rsp_last
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int IDX_W  = LEN_W + 1;
  localparam int TC_W   = $clog2(XFER_CYC + 1);

  logic [IDX_W-1:0]  widx_q;
  logic [TC_W-1:0]   tcnt_q;
  logic [TC_W-1:0]   tcnt_d;
  logic [BANK_W-1:0] cur_bank;
  logic              more;
  logic              go;
  logic              valid_q;
  logic              last_q;
  logic [DATA_W-1:0] data_q;

  assign cur_bank = first_bank + widx_q[BANK_W-1:0];
  assign more     = (widx_q <= IDX_W'(last_idx));
  assign go       = active && more && (tcnt_q == '0) && bank_rdy[cur_bank];

  always_comb begin
    take = '0;
    if (go) take[cur_bank] = 1'b1;
    if (go)                 tcnt_d = TC_W'(XFER_CYC - 1);
    else if (tcnt_q != '0)  tcnt_d = tcnt_q - 1'b1;
    else                    tcnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (go) begin
      data_q <= bank_data[cur_bank];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      widx_q  <= '0;
      tcnt_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      tcnt_q  <= tcnt_d;
      valid_q <= (tcnt_d == TC_W'(1));
      last_q  <= (tcnt_d == TC_W'(1)) && (widx_q == IDX_W'(last_idx));
      if (tcnt_q == TC_W'(1)) widx_q <= widx_q + 1'b1;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_data  = data_q;
  assign rsp_last  = last_q;

endmodule

// File: rtl/ilv_fill_ctrl.sv
// Top: request capture, address phase and fill sequencing over the bank array.
module ilv_fill_ctrl
  import ilv_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 4,
  parameter int NUM_BANKS = 4,
  parameter int ADDR_CYC  = 4,
  parameter int ACC_CYC   = 24,
  parameter int XFER_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_done
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int AC_W   = $clog2(ADDR_CYC + 1);

  fill_state_e       state_q;
  logic [AC_W-1:0]   acnt_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic              ready_q;
  logic              done_q;
  logic              accept;
  logic              issue_en;
  logic              active;
  logic              rsp_last;

  logic [NUM_BANKS-1:0]             bank_start;
  logic [NUM_BANKS-1:0]             bank_busy;
  logic [NUM_BANKS-1:0]             bank_rdy;
  logic [NUM_BANKS-1:0]             bank_take;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  bank_row;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data;

  assign accept   = req_valid && ready_q;
  assign issue_en = (state_q == FILL_RUN) ||
                    ((state_q == FILL_ADDR) && (acnt_q == AC_W'(1)));
  assign active   = (state_q != FILL_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FILL_IDLE;
      acnt_q  <= '0;
      base_q  <= '0;
      len_q   <= '0;
      ready_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        FILL_IDLE: begin
          if (accept) begin
            state_q <= FILL_ADDR;
            acnt_q  <= AC_W'(ADDR_CYC - 1);
            base_q  <= req_addr;
            len_q   <= req_len;
            ready_q <= 1'b0;
          end
        end
        FILL_ADDR: begin
          acnt_q <= acnt_q - 1'b1;
          if (acnt_q == AC_W'(1)) state_q <= FILL_RUN;
        end
        FILL_RUN: begin
          if (rsp_valid && rsp_last) begin
            state_q <= FILL_IDLE;
            ready_q <= 1'b1;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= FILL_IDLE;
      endcase
    end
  end

  ilv_issue #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .ROW_W    (ROW_W)
  ) u_issue (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .en       (issue_en),
    .base     (base_q),
    .last_idx (len_q),
    .bank_busy(bank_busy),
    .bank_rdy (bank_rdy),
    .bank_take(bank_take),
    .start    (bank_start),
    .row      (bank_row)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ilv_bank #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_BANKS(NUM_BANKS),
      .BANK_IDX (b),
      .ACC_CYC  (ACC_CYC),
      .ROW_W    (ROW_W)
    ) u_bank (
      .clk  (clk),
      .rst  (rst),
      .start(bank_start[b]),
      .row  (bank_row[b]),
      .take (bank_take[b]),
      .busy (bank_busy[b]),
      .rdy  (bank_rdy[b]),
      .data (bank_data[b])
    );
  end

  ilv_return #(
    .NUM_BANKS(NUM_BANKS),
    .DATA_W   (DATA_W),
    .LEN_W    (LEN_W),
    .XFER_CYC (XFER_CYC)
  ) u_return (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .active    (active),
    .first_bank(base_q[BANK_W-1:0]),
    .last_idx  (len_q),
    .bank_rdy  (bank_rdy),
    .bank_data (bank_data),
    .take      (bank_take),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last)
  );

  assign req_ready = ready_q;
  assign rsp_done  = done_q;

endmodule

// File: rtl/ilv_fill_chk.sv
// Property checker attached to the fill controller.
module ilv_fill_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_CYC  = 4,
  parameter int ACC_CYC   = 24,
  parameter int XFER_CYC  = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic                 rsp_done,
  input logic [NUM_BANKS-1:0] bank_busy,
  input logic [NUM_BANKS-1:0] bank_rdy
);

  localparam int FIRST_CYC = ADDR_CYC + ACC_CYC + XFER_CYC - 1;
  localparam logic [15:0] SAT = 16'hFFFF;

  logic [15:0] since_acc;
  logic [15:0] since_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_acc <= '0;
      since_val <= SAT;
    end else begin
      if (req_valid && req_ready)                 since_acc <= 16'd1;
      else if (since_acc != '0 && since_acc != SAT) since_acc <= since_acc + 1'b1;
      if (rsp_valid)             since_val <= 16'd1;
      else if (since_val != SAT) since_val <= since_val + 1'b1;
    end
  end

  // R4
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  no_ready_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  // R5
  first_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (since_acc >= 16'(FIRST_CYC)));

  // R7
  word_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (since_val >= 16'(XFER_CYC)));

  // R9
  done_after_word_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(rsp_valid));

  // R9
  done_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    // R8
    bank_slot_chk: assert property (@(posedge clk) disable iff (rst)
      !(bank_busy[b] && bank_rdy[b]));
  end

endmodule

bind ilv_fill_ctrl ilv_fill_chk #(
  .NUM_BANKS(NUM_BANKS),
  .ADDR_CYC (ADDR_CYC),
  .ACC_CYC  (ACC_CYC),
  .XFER_CYC (XFER_CYC)
) u_fill_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_done (rsp_done),
  .bank_busy(bank_busy),
  .bank_rdy (bank_rdy)
);

// File: tb/tb_ilv_fill_ctrl.sv
`timescale 1ns/1ps
module tb_ilv_fill_ctrl;

  localparam int ADDR_CYC = 4;
  localparam int ACC_CYC  = 24;
  localparam int XFER_CYC = 4;

  // {start address[31:20], len[19:16], expected last valid cycle[15:0]}
  localparam int NVEC = 7;
  localparam logic [31:0] VEC [NVEC] = '{
    {12'h010, 4'd1,  16'd35},   // R6
    {12'h023, 4'd0,  16'd31},   // R5
    {12'h101, 4'd3,  16'd43},   // R7
    {12'h200, 4'd7,  16'd68},   // R8
    {12'hFFE, 4'd3,  16'd43},   // R10
    {12'h005, 4'd15, 16'd118},  // R8
    {12'h007, 4'd5,  16'd60}    // R8
  };
  localparam string VTAG [NVEC] = '{"R6", "R5", "R7", "R8", "R10", "R8", "R8"};

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [11:0] req_addr;
  logic [3:0]  req_len;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_done;

  int checks = 0;
  int errors = 0;
  int exp_e [16];

  always #10 clk = ~clk;

  ilv_fill_ctrl dut (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .req_len  (req_len),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .rsp_done (rsp_done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [11:0] a);
    logic [63:0] p;
    p = {52'd0, a} * 64'h0000_0000_9E37_79B1;
    return p[31:0];
  endfunction

  // Valid cycle of each word, from the timing rules of R5, R7 and R8
  task automatic model_fill(input int len);
    int s [16];
    for (int i = 0; i <= len; i++) begin
      int rdy_c;
      int st;
      rdy_c = (i < 4) ? (ADDR_CYC + ACC_CYC) : (s[i-4] + 1 + ACC_CYC);
      st    = (i == 0) ? rdy_c : ((rdy_c > exp_e[i-1] + 1) ? rdy_c : exp_e[i-1] + 1);
      s[i]     = st;
      exp_e[i] = st + XFER_CYC - 1;
    end
  endtask

  // Called at the falling edge of a cycle in which the controller is idle
  task automatic run_fill(input logic [11:0] a, input logic [3:0] l,
                          input int exp_last, input string ttag, input bit noise);
    int  got;
    int  done_c;
    int  last_c;
    bit  ready_seen;
    string dtag;
    dtag = (ttag == "R10") ? "R10" : "R2";
    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    model_fill(int'(l));
    req_addr  = a;
    req_len   = l;
    req_valid = 1'b1;
    got = 0; done_c = -1; last_c = -1; ready_seen = 1'b0;
    for (int c = 1; c <= 400 && done_c < 0; c++) begin
      @(negedge clk);
      if (!noise || c > 10) req_valid = 1'b0;
      else begin
        req_addr = a ^ 12'hFFF;
        req_len  = 4'd0;
      end
      if (rsp_valid) begin
        if (got <= int'(l)) begin
          chk(rsp_data == exp_word(a + 12'(got)), dtag, rsp_data, exp_word(a + 12'(got)));
          chk(c == exp_e[got], (got == 0) ? "R5" : ((got < 4) ? "R7" : "R8"), c, exp_e[got]);
        end
        got++;
        last_c = c;
      end
      if (rsp_done) begin
        done_c = c;
        chk(req_ready == 1'b1, "R9 ready in done cycle", req_ready, 1);
      end else if (req_ready) begin
        ready_seen = 1'b1;
      end
    end
    chk(!ready_seen, "R4 ready low during fill", ready_seen, 0);
    chk(got == int'(l) + 1, "R3 word count", got, int'(l) + 1);
    chk(last_c == exp_last, ttag, last_c, exp_last);
    chk(done_c == last_c + 1, "R9 done cycle", done_c, last_c + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog: run reached %0d cycles, expected fewer", 200000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst       = 1'b1;
    req_valid = 1'b0;
    req_addr  = '0;
    req_len   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 valid", rsp_valid, 0);
    chk(rsp_done == 1'b0, "R1 done", rsp_done, 0);

    // R4: other requests held on the port during a fill are ignored
    run_fill(12'h040, 4'd1, 35, "R4", 1'b1);

    // Table of fills, each started in the done cycle of the previous (R9)
    for (int i = 0; i < NVEC; i++) begin
      run_fill(VEC[i][31:20], VEC[i][19:16], int'(VEC[i][15:0]), VTAG[i], 1'b0);
    end

    // After the last fill the controller is idle with nothing pending (R9)
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 no word after done", rsp_valid, 0);
    chk(rsp_done == 1'b0, "R9 done single cycle", rsp_done, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule